// File: doc/BRIEF.md
# PCI Target Read Termination Controller

This block decides, clock by clock, how a PCI target answers a master read that is served from a read-data FIFO filled by slower user logic. For every data phase it chooses whether to present data, insert a wait-state, retry the master or disconnect without data. The choice depends on the FIFO flags, a selectable initial latency limit, a fixed subsequent latency window, a burst-pending hint from the user side, and a hold-off input that makes buffered data invisible to the bus.

In delayed mode, a read that finds nothing pending is retried at once. Its address and command are latched and offered to the user side through an active-low request. Every later read is retried until three conditions hold: the user has taken the stored address, data is present, and the same address and command come back. That read is then completed like a direct read. Outside delayed mode the first data phase waits for data instead of retrying. Address decode, configuration space, parity and the FIFO storage sit outside the block.

Top module: `pci_rd_term_ctrl`

## Requirements
- R1: Outside delayed mode, an accepted read enters a first data phase one clock after `rd_start`. There, each clock with an effectively empty FIFO is a wait-state with `data_valid` low. The first clock with data raises `data_valid`. `data_valid` is never high while `fifo_empty` is high.
- R2: In the first data phase, `retry` rises on the Nth consecutive empty clock and the transaction ends. N is 16 when `lat_sel`=0 and 32 when `lat_sel`=1.
- R3: With `delayed_en`=1 and no read pending, `rd_start` gives `retry` in the same clock. `req_addr`/`req_cmd` are latched onto `stored_addr`/`stored_cmd`, and `user_req_n` is low from the next clock.
- R4: While a delayed read is pending, `rd_start` is answered with `retry` unless all of the following hold: `addr_ack` has been seen since the capture, the FIFO is effectively non-empty, and both address and command equal the stored ones. When they all hold, the read proceeds to a first data phase with no `retry`.
- R5: After the first word, an effectively empty clock with `burst_hint`=0 gives `disc` in that same clock and ends the transaction.
- R6: After the first word with `burst_hint`=1, empty clocks are wait-states and `disc` rises on the 8th consecutive one. Data arriving earlier resumes `data_valid` and restarts the count.
- R7: When `hold_off`=1 and `fifo_full`=0, the FIFO is treated as empty: `data_valid` stays low and a new direct read is retried. `fifo_full`=1 overrides the hold-off.
- R8: `last_in` together with `data_valid` ends the transaction normally, even with data left in the FIFO. `user_req_n` is high from the next clock.
- R9: `abort_in` returns the block to idle at the next clock from any state and clears any pending delayed read. `user_req_n` is high at the next clock.
- R10: After reset, `user_req_n`=1, `data_valid`, `retry` and `disc` are low, and no delayed read is pending.
- R11: At most one of `data_valid`, `retry` and `disc` is high in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lat_sel | input | 1 | Initial latency limit: 0 = 16 clocks, 1 = 32 clocks |
| delayed_en | input | 1 | Delayed-transaction mode, static between transactions |
| burst_hint | input | 1 | More data is on its way; wait instead of disconnecting |
| hold_off | input | 1 | Hide FIFO contents from the bus |
| rd_start | input | 1 | Master read address phase this clock |
| req_addr | input | AW | Address of the read |
| req_cmd | input | CW | Bus command of the read |
| last_in | input | 1 | Master's final data phase |
| abort_in | input | 1 | Transaction aborted |
| fifo_empty | input | 1 | Read FIFO empty |
| fifo_full | input | 1 | Read FIFO full |
| addr_ack | input | 1 | User side has taken the stored address |
| data_valid | output | 1 | Data presented, FIFO word consumed |
| retry | output | 1 | Retry termination this clock |
| disc | output | 1 | Disconnect without data this clock |
| user_req_n | output | 1 | Active-low request to user logic |
| stored_addr | output | AW | Captured delayed-read address |
| stored_cmd | output | CW | Captured delayed-read command |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 4-bit command, initial limits of 16 and 32 clocks and a subsequent window of 8. With these values both initial timeouts and the full burst wait window can be counted clock by clock in a short run. Delayed-read matching is exercised with reads that differ only in address or only in command.

// File: rtl/pci_rd_term_pkg.sv
package pci_rd_term_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FIRST = 2'd1,
        PH_BURST = 2'd2
    } phase_e;
endpackage

// File: rtl/pci_rd_lat_cnt.sv
module pci_rd_lat_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/pci_rd_dly_track.sv
module pci_rd_dly_track #(
    parameter int AW = 32,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          clear,
    input  logic          ack,
    input  logic [AW-1:0] in_addr,
    input  logic [CW-1:0] in_cmd,
    output logic          pending,
    output logic          consumed,
    output logic          match,
    output logic [AW-1:0] st_addr,
    output logic [CW-1:0] st_cmd
);
    typedef struct packed {
        logic          pend;
        logic          took;
        logic [AW-1:0] addr;
        logic [CW-1:0] cmd;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (clear) begin
            trk_d.pend = 1'b0;
            trk_d.took = 1'b0;
        end else if (capture) begin
            trk_d.pend = 1'b1;
            trk_d.took = 1'b0;
            trk_d.addr = in_addr;
            trk_d.cmd  = in_cmd;
        end else if (ack && trk_q.pend) begin
            trk_d.took = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign pending  = trk_q.pend;
    assign consumed = trk_q.took;
    assign match    = trk_q.pend && (in_addr == trk_q.addr) && (in_cmd == trk_q.cmd);
    assign st_addr  = trk_q.addr;
    assign st_cmd   = trk_q.cmd;
endmodule

// File: rtl/pci_rd_term_ctrl.sv
module pci_rd_term_ctrl
    import pci_rd_term_pkg::*;
#(
    parameter int AW        = 32,
    parameter int CW        = 4,
    parameter int LAT_SHORT = 16,
    parameter int LAT_LONG  = 32,
    parameter int SUB_LAT   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lat_sel,
    input  logic          delayed_en,
    input  logic          burst_hint,
    input  logic          hold_off,
    input  logic          rd_start,
    input  logic [AW-1:0] req_addr,
    input  logic [CW-1:0] req_cmd,
    input  logic          last_in,
    input  logic          abort_in,
    input  logic          fifo_empty,
    input  logic          fifo_full,
    input  logic          addr_ack,
    output logic          data_valid,
    output logic          retry,
    output logic          disc,
    output logic          user_req_n,
    output logic [AW-1:0] stored_addr,
    output logic [CW-1:0] stored_cmd
);
    localparam int MAXL = (LAT_LONG > SUB_LAT) ? LAT_LONG : SUB_LAT;
    localparam int CNTW = $clog2(MAXL + 1);
    localparam logic [CNTW-1:0] LIM_S   = CNTW'(LAT_SHORT - 1);
    localparam logic [CNTW-1:0] LIM_L   = CNTW'(LAT_LONG - 1);
    localparam logic [CNTW-1:0] LIM_SUB = CNTW'(SUB_LAT - 1);

    typedef struct packed {
        phase_e phase;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic            pending, consumed, match;
    logic [CNTW-1:0] cnt;
    logic            cnt_clr, cnt_inc, cap, clr_pend;
    logic            hold_act, eff_empty;
    logic [CNTW-1:0] lim_first;

    assign hold_act  = hold_off && !fifo_full;
    assign eff_empty = fifo_empty || hold_act;
    assign lim_first = lat_sel ? LIM_L : LIM_S;

    always_comb begin
        ctl_d      = ctl_q;
        data_valid = 1'b0;
        retry      = 1'b0;
        disc       = 1'b0;
        cap        = 1'b0;
        clr_pend   = 1'b0;
        cnt_clr    = 1'b0;
        cnt_inc    = 1'b0;
        if (abort_in) begin
            ctl_d.phase = PH_IDLE;
            clr_pend    = 1'b1;
            cnt_clr     = 1'b1;
        end else begin
            case (ctl_q.phase)
                PH_IDLE: begin
                    cnt_clr = 1'b1;
                    if (rd_start) begin
                        if (delayed_en) begin
                            if (!pending) begin
                                retry = 1'b1;
                                cap   = 1'b1;
                            end else if (match && consumed && !eff_empty) begin
                                ctl_d.phase = PH_FIRST;
                                clr_pend    = 1'b1;
                            end else begin
                                retry = 1'b1;
                            end
                        end else if (hold_act) begin
                            retry = 1'b1;
                        end else begin
                            ctl_d.phase = PH_FIRST;
                        end
                    end
                end
                PH_FIRST: begin
                    if (!eff_empty) begin
                        data_valid  = 1'b1;
                        cnt_clr     = 1'b1;
                        ctl_d.phase = last_in ? PH_IDLE : PH_BURST;
                    end else if (cnt == lim_first) begin
                        retry       = 1'b1;
                        cnt_clr     = 1'b1;
                        ctl_d.phase = PH_IDLE;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                PH_BURST: begin
                    if (!eff_empty) begin
                        data_valid = 1'b1;
                        cnt_clr    = 1'b1;
                        if (last_in) ctl_d.phase = PH_IDLE;
                    end else if (!burst_hint || cnt == LIM_SUB) begin
                        disc        = 1'b1;
                        cnt_clr     = 1'b1;
                        ctl_d.phase = PH_IDLE;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                default: ctl_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{phase: PH_IDLE};
        else        ctl_q <= ctl_d;
    end

    pci_rd_lat_cnt #(.W(CNTW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (cnt)
    );

    pci_rd_dly_track #(.AW(AW), .CW(CW)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (cap),
        .clear    (clr_pend),
        .ack      (addr_ack),
        .in_addr  (req_addr),
        .in_cmd   (req_cmd),
        .pending  (pending),
        .consumed (consumed),
        .match    (match),
        .st_addr  (stored_addr),
        .st_cmd   (stored_cmd)
    );

    assign user_req_n = !(pending || (ctl_q.phase != PH_IDLE));
endmodule

// File: rtl/pci_rd_term_chk.sv
module pci_rd_term_chk
    import pci_rd_term_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          delayed_en,
    input logic          burst_hint,
    input logic          hold_off,
    input logic          rd_start,
    input logic          abort_in,
    input logic          fifo_empty,
    input logic          fifo_full,
    input logic [AW-1:0] req_addr,
    input logic          data_valid,
    input logic          retry,
    input logic          disc,
    input logic          user_req_n,
    input logic [AW-1:0] stored_addr,
    input logic          pending,
    input phase_e        phase
);
    // R11
    term_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_valid, retry, disc}));

    // R1
    valid_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> !fifo_empty);

    // R7
    hold_hides_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_off && !fifo_full) |-> !data_valid);

    // R5
    empty_no_hint_disc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_BURST && fifo_empty && !burst_hint && !abort_in) |-> disc);

    // R9
    abort_releases_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_in |=> user_req_n);

    // R3
    capture_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && rd_start && delayed_en && !pending && !abort_in)
        |=> (!user_req_n && stored_addr == $past(req_addr)));
endmodule

bind pci_rd_term_ctrl pci_rd_term_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .delayed_en  (delayed_en),
    .burst_hint  (burst_hint),
    .hold_off    (hold_off),
    .rd_start    (rd_start),
    .abort_in    (abort_in),
    .fifo_empty  (fifo_empty),
    .fifo_full   (fifo_full),
    .req_addr    (req_addr),
    .data_valid  (data_valid),
    .retry       (retry),
    .disc        (disc),
    .user_req_n  (user_req_n),
    .stored_addr (stored_addr),
    .pending     (pending),
    .phase       (ctl_q.phase)
);

// File: tb/pci_rd_term_ctrl_tb.sv
module pci_rd_term_ctrl_tb;
    localparam int AW = 32;
    localparam int CW = 4;
    localparam logic [AW-1:0] ADDR_A = 32'h1000_0040;
    localparam logic [AW-1:0] ADDR_B = 32'h2000_0080;
    localparam logic [CW-1:0] CMD_RD = 4'h6;
    localparam logic [CW-1:0] CMD_ML = 4'hE;

    // {rs de ls bh ho li ab}_{fe ff ak as}_{dv rt dc un}
    localparam int NV = 39;
    localparam logic [14:0] VEC [NV] = '{
        15'b0000000_1000_0001, 15'b1000000_1000_0001, 15'b0000000_1000_0000,
        15'b0000000_0000_1000, 15'b0000000_0000_1000, 15'b0000000_1000_0010,
        15'b0000000_1000_0001, 15'b1000000_0000_0001, 15'b0000010_0000_1000,
        15'b0000000_0000_0001, 15'b1000000_0000_0001, 15'b0000000_0000_1000,
        15'b0001000_1000_0000, 15'b0001000_0000_1000, 15'b0001010_0000_1000,
        15'b1000100_0000_0101, 15'b1000100_0100_0001, 15'b0000110_0100_1000,
        15'b1000000_0000_0001, 15'b0000100_0000_0000, 15'b0000010_0000_1000,
        15'b1000000_1000_0001, 15'b0000001_1000_0000, 15'b0000000_1000_0001,
        15'b1100000_1000_0101, 15'b0100000_1000_0000, 15'b1100000_0000_0100,
        15'b0100000_0010_0000, 15'b1100000_0001_0100, 15'b1100000_1000_0100,
        15'b1100000_0000_0000, 15'b0100010_0000_1000, 15'b0100000_0000_0001,
        15'b1100000_1000_0101, 15'b0100001_1000_0000, 15'b0100000_1000_0001,
        15'b1100000_1000_0101, 15'b0100001_1000_0000, 15'b0000000_1000_0001
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lat_sel = 1'b0, delayed_en = 1'b0, burst_hint = 1'b0, hold_off = 1'b0;
    logic rd_start = 1'b0, last_in = 1'b0, abort_in = 1'b0;
    logic fifo_empty = 1'b1, fifo_full = 1'b0, addr_ack = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_cmd = '0;
    logic data_valid, retry, disc, user_req_n;
    logic [AW-1:0] stored_addr;
    logic [CW-1:0] stored_cmd;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pci_rd_term_ctrl #(.AW(AW), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .lat_sel(lat_sel), .delayed_en(delayed_en),
        .burst_hint(burst_hint), .hold_off(hold_off), .rd_start(rd_start),
        .req_addr(req_addr), .req_cmd(req_cmd), .last_in(last_in),
        .abort_in(abort_in), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .addr_ack(addr_ack), .data_valid(data_valid), .retry(retry),
        .disc(disc), .user_req_n(user_req_n), .stored_addr(stored_addr),
        .stored_cmd(stored_cmd)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string vtag(input int i);
        if (i <= 6)       return "R1 R5 vector";
        else if (i <= 9)  return "R8 vector";
        else if (i <= 14) return "R6 vector";
        else if (i <= 20) return "R7 vector";
        else if (i <= 23) return "R9 vector";
        else if (i <= 32) return "R3 R4 vector";
        else              return "R9 R11 vector";
    endfunction

    task automatic idle_in();
        rd_start = 0; last_in = 0; abort_in = 0; addr_ack = 0;
        hold_off = 0; fifo_full = 0; burst_hint = 0; delayed_en = 0;
        req_cmd = CMD_RD; req_addr = ADDR_A;
    endtask

    task automatic outs(input string tag, input logic [3:0] exp);
        check(tag, {data_valid, retry, disc, user_req_n}, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        req_cmd = CMD_RD;
        req_addr = ADDR_A;
        #35;
        // R10 reset state
        outs("R10 reset outputs", 4'b0001);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {rd_start, delayed_en, lat_sel, burst_hint, hold_off, last_in, abort_in} = VEC[i][14:8];
            {fifo_empty, fifo_full, addr_ack} = VEC[i][7:5];
            req_addr = VEC[i][4] ? ADDR_B : ADDR_A;
            req_cmd = CMD_RD;
            #2;
            outs(vtag(i), VEC[i][3:0]);
        end

        // R2 first-phase timeout, both limits
        for (int s = 0; s < 2; s++) begin
            @(negedge clk);
            idle_in(); lat_sel = s[0]; fifo_empty = 1; rd_start = 1;
            #2;
            for (int k = 1; k <= (s == 0 ? 16 : 32); k++) begin
                @(negedge clk);
                rd_start = 0;
                #2;
                check("R2 first-phase timeout", {63'd0, retry}, {63'd0, (k == (s == 0 ? 16 : 32))});
            end
            @(negedge clk);
            #2;
            check("R2 ended after timeout", {63'd0, user_req_n}, 64'd1);
        end

        // R6 subsequent window of 8 with hint
        @(negedge clk);
        idle_in(); fifo_empty = 0; rd_start = 1;
        @(negedge clk);
        rd_start = 0;
        #2;
        check("R6 first word", {63'd0, data_valid}, 64'd1);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            fifo_empty = 1; burst_hint = 1;
            #2;
            check("R6 burst window", {62'd0, disc, data_valid}, {62'd0, (k == 8), 1'b0});
        end

        // R3 captured address and command
        @(negedge clk);
        idle_in(); delayed_en = 1; fifo_empty = 1; rd_start = 1;
        req_addr = ADDR_B; req_cmd = CMD_RD;
        #2;
        check("R3 capture retry", {63'd0, retry}, 64'd1);
        @(negedge clk);
        rd_start = 0; addr_ack = 1; req_addr = '0;
        #2;
        check("R3 stored address", {32'd0, stored_addr}, {32'd0, ADDR_B});
        check("R3 stored command", {60'd0, stored_cmd}, {60'd0, CMD_RD});
        check("R3 request low", {63'd0, user_req_n}, 64'd0);
        // R4 command-only mismatch is retried
        @(negedge clk);
        addr_ack = 0; fifo_empty = 0; rd_start = 1; req_addr = ADDR_B; req_cmd = CMD_ML;
        #2;
        check("R4 command mismatch", {63'd0, retry}, 64'd1);
        @(negedge clk);
        req_cmd = CMD_RD;
        #2;
        check("R4 match completes", {63'd0, retry}, 64'd0);
        @(negedge clk);
        rd_start = 0; last_in = 1;
        #2;
        check("R4 completion data", {63'd0, data_valid}, 64'd1);
        @(negedge clk);
        idle_in(); delayed_en = 1;
        #2;
        check("R8 request released", {63'd0, user_req_n}, 64'd1);

        // R10 reset mid-pending
        @(negedge clk);
        rd_start = 1; fifo_empty = 1;
        @(negedge clk);
        rd_start = 0; rst_n = 0;
        #2;
        check("R10 reset clears pending", {63'd0, user_req_n}, 64'd1);
        rst_n = 1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule